// File: doc/BRIEF.md
# Uncore Event Counter Unit

This unit gives software a bank of hardware event counters for one uncore agent. The counters are controlled over a plain 32-bit register bus. The agent presents its event pulses as a 256-bit vector, one bit per event code. Software binds each counter to an 8-bit code, turns on the counters it wants, and then starts or stops all of them at once with a single global bit.

Each counter is 48 bits wide. Software reaches it as two 32-bit words: the low word holds bits [31:0] and the word above it holds bits [47:32]. The top 16 bits of the upper word always read as zero, and writes to them are dropped. When a counter wraps past its maximum value, it sets a pending bit. Any pending bit that software has not masked drives the interrupt line. Software clears a pending bit by writing a one to it in a separate clear register. A read-only identifier lets software tell which counter-count variant is fitted.

Reads have no side effects, and the read data follows the address in the same cycle. Writes take effect at the next clock edge.

Top module: `uncore_evt_counters`

## Requirements
- R1: After reset, every counter, every counter enable, the global enable and every pending bit are 0. Every mask bit is 1, and every event-select byte is 0xFF.
- R2: Counter n has its low word at 0x1F00+8n, holding bits [31:0], and its high word at 0x1F04+8n, holding bits [47:32] in data bits [15:0]. High-word bits [31:16] read as 0, and writes to them are ignored. A write to one word leaves the other word unchanged.
- R3: A counter that increments from 2^48-1 wraps to 0 and sets its pending bit n. No pending bit is set before the wrap.
- R4: Counter n takes its event code from bits [8*(n mod 4)+7 : 8*(n mod 4)] of the select register at 0x1E80+4*(n/4). It increments once per clock in which the event-vector bit at that code is 1.
- R5: A select code of 0xFF never increments its counter, even while event bit 255 is 1.
- R6: A counter increments only while bit 0 of 0x1E00 (the global enable) is 1 and bit n of 0x1E04 (its own enable) is also 1.
- R7: In the mask register at 0x0804, a 0 in bit n lets pending bit n drive irq and a 1 masks it. irq is the OR of all pending bits that are not masked.
- R8: The pending register at 0x0808 shows one bit per counter. Writing 1 to bit n of 0x080C clears pending bit n only, and leaves every other pending bit unchanged.
- R9: A read of 0x1CF0 returns the VERSION_ID parameter.
- R10: A bus write to a counter word in the same cycle as an enabled event loads the written value, and that cycle's increment is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, available in the same cycle |
| evt_in | input | 256 | Event pulses, bit k for event code k |
| irq | output | 1 | Overflow interrupt, high while any unmasked pending bit is set |

## Verification
The bench builds the unit with its defaults: 16 counters of 48 bits. This places counter 15 and the last select register within reach, so the top edge of the address map is tested. Because the two halves of a counter can be written directly, a counter can be preloaded to one step below 2^48-1, and the wrap appears within two event pulses rather than after 2^48 events. The default width also makes the high word carry 16 real bits, so the read-as-zero upper bits are exercised against data that is really stored.

// File: rtl/uncore_evt_counters.sv
module uncore_evt_counters #(
  parameter int          NUM_CNT    = 16,
  parameter int          CNT_W      = 48,
  parameter logic [31:0] VERSION_ID = 32'h0000_0010
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [15:0]  bus_addr,
  input  logic         bus_wr,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  input  logic [255:0] evt_in,
  output logic         irq
);
  localparam int HI_W    = CNT_W - 32;
  localparam int NUM_SEL = NUM_CNT / 4;
  localparam logic [15:0] A_MASK = 16'h0804;
  localparam logic [15:0] A_STAT = 16'h0808;
  localparam logic [15:0] A_CLR  = 16'h080C;
  localparam logic [15:0] A_VER  = 16'h1CF0;
  localparam logic [15:0] A_CTRL = 16'h1E00;
  localparam logic [15:0] A_EN   = 16'h1E04;
  localparam logic [15:0] A_SEL  = 16'h1E80;
  localparam logic [15:0] A_CNT  = 16'h1F00;

  logic               glob_en;
  logic [NUM_CNT-1:0] cnt_en, irq_mask, pend, ovf;
  logic [7:0]         sel_q [NUM_CNT];
  logic [CNT_W-1:0]   cnt_q [NUM_CNT];

  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_en   = bus_wr && bus_addr == A_EN;
  wire wr_mask = bus_wr && bus_addr == A_MASK;
  wire wr_clr  = bus_wr && bus_addr == A_CLR;
  wire [NUM_CNT-1:0] clr_bits = wr_clr ? bus_wdata[NUM_CNT-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en  <= 1'b0;
      cnt_en   <= '0;
      irq_mask <= '1;
      pend     <= '0;
    end else begin
      if (wr_ctrl) glob_en  <= bus_wdata[0];
      if (wr_en)   cnt_en   <= bus_wdata[NUM_CNT-1:0];
      if (wr_mask) irq_mask <= bus_wdata[NUM_CNT-1:0];
      pend <= (pend & ~clr_bits) | ovf;
    end
  end

  assign irq = |(pend & ~irq_mask);

  genvar n;
  generate
    for (n = 0; n < NUM_CNT; n++) begin : g_cnt
      localparam logic [15:0] LO_A  = A_CNT + 16'(8 * n);
      localparam logic [15:0] HI_A  = LO_A + 16'd4;
      localparam logic [15:0] SEL_A = A_SEL + 16'(4 * (n / 4));
      localparam int          LANE  = 8 * (n % 4);

      wire hit_lo  = bus_wr && bus_addr == LO_A;
      wire hit_hi  = bus_wr && bus_addr == HI_A;
      wire hit_sel = bus_wr && bus_addr == SEL_A;
      wire inc     = glob_en && cnt_en[n] && sel_q[n] != 8'hFF && evt_in[sel_q[n]];
      assign ovf[n] = inc && !hit_lo && !hit_hi && (&cnt_q[n]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q[n] <= '0;
          sel_q[n] <= 8'hFF;
        end else begin
          if (hit_sel) sel_q[n] <= bus_wdata[LANE +: 8];
          if (hit_lo)      cnt_q[n][31:0]       <= bus_wdata;
          else if (hit_hi) cnt_q[n][CNT_W-1:32] <= bus_wdata[HI_W-1:0];
          else if (inc)    cnt_q[n]             <= cnt_q[n] + {{(CNT_W-1){1'b0}}, 1'b1};
        end
      end

      p_wrap_sets_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf[n] |=> pend[n] && cnt_q[n] == '0);
      p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en || !cnt_en[n]) && !hit_lo && !hit_hi |=> $stable(cnt_q[n]));
      p_code_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q[n] == 8'hFF && !hit_lo && !hit_hi |=> $stable(cnt_q[n]));
      p_clear_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr && bus_wdata[n] && !ovf[n] |=> !pend[n]);
      p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_lo |=> cnt_q[n][31:0] == $past(bus_wdata));
      p_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr == HI_A |-> (bus_rdata >> HI_W) == 32'd0);
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MASK:  bus_rdata = 32'(irq_mask);
      A_STAT:  bus_rdata = 32'(pend);
      A_VER:   bus_rdata = VERSION_ID;
      A_CTRL:  bus_rdata = {31'd0, glob_en};
      A_EN:    bus_rdata = 32'(cnt_en);
      default: bus_rdata = '0;
    endcase
    for (int s = 0; s < NUM_SEL; s++)
      if (bus_addr == A_SEL + 16'(4 * s))
        bus_rdata = {sel_q[4*s+3], sel_q[4*s+2], sel_q[4*s+1], sel_q[4*s]};
    for (int c = 0; c < NUM_CNT; c++) begin
      if (bus_addr == A_CNT + 16'(8 * c))      bus_rdata = cnt_q[c][31:0];
      if (bus_addr == A_CNT + 16'(8 * c + 4))  bus_rdata = 32'(cnt_q[c][CNT_W-1:32]);
    end
  end

  p_all_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (&irq_mask) |-> !irq);
  p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pend == '0 && (&irq_mask));
endmodule

// File: tb/sim_uncore_evt_counters.sv
`timescale 1ns/1ps
module sim_uncore_evt_counters;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [255:0] evt = '0;
  logic         irq;

  int tests = 0;
  int fails = 0;
  logic rd_pend = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  uncore_evt_counters #(.NUM_CNT(16), .CNT_W(48), .VERSION_ID(32'h0000_0010)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt), .irq(irq));

  always @(negedge clk) begin
    if (rd_pend) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (bus_rdata !== e) begin
        fails++;
        $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    bus_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_pend = 1'b1;
    @(posedge clk); #1;
    rd_pend = 1'b0;
  endtask

  task automatic pulse(input int code, input int k);
    @(posedge clk); #1;
    evt[code] = 1'b1; evt[255] = 1'b1;
    repeat (k) @(posedge clk);
    #1;
    evt = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    tests++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: irq got %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(16'h1E00, 32'h0, "R1 global enable");
    rd(16'h1E04, 32'h0, "R1 counter enables");
    rd(16'h0804, 32'h0000FFFF, "R1 mask");
    rd(16'h0808, 32'h0, "R1 pending");
    rd(16'h1E80, 32'hFFFFFFFF, "R1 select reg 0");
    rd(16'h1E8C, 32'hFFFFFFFF, "R1 select reg 3");
    rd(16'h1F00, 32'h0, "R1 counter 0 low");
    rd(16'h1F7C, 32'h0, "R1 counter 15 high");
    chk_irq(1'b0, "R1 irq");
    rd(16'h1CF0, 32'h0000_0010, "R9 version");

    wr(16'h1F18, 32'h12345678);
    wr(16'h1F1C, 32'hABCD9876);
    rd(16'h1F18, 32'h12345678, "R2 counter 3 low");
    rd(16'h1F1C, 32'h00009876, "R2 counter 3 high");
    rd(16'h1F10, 32'h0, "R2 counter 2 untouched");
    wr(16'h1F78, 32'hCAFEF00D);
    rd(16'h1F78, 32'hCAFEF00D, "R2 counter 15 low");
    rd(16'h1F7C, 32'h0, "R2 counter 15 high kept");

    wr(16'h1E84, 32'hFFFF03FF);
    wr(16'h1E04, 32'h000000F0);
    pulse(3, 3);
    rd(16'h1F28, 32'h0, "R6 global off");
    wr(16'h1E00, 32'h1);
    pulse(3, 3);
    rd(16'h1F28, 32'h3, "R4 counter 5 lane 1");
    rd(16'h1F20, 32'h0, "R5 counter 4 code none");
    rd(16'h1F30, 32'h0, "R5 counter 6 code none");
    wr(16'h1E04, 32'h000000D0);
    pulse(3, 2);
    rd(16'h1F28, 32'h3, "R6 own enable off");

    wr(16'h1E04, 32'h000000F0);
    @(posedge clk); #1;
    evt[3] = 1'b1; bus_addr = 16'h1F28; bus_wdata = 32'd100; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; evt = '0;
    rd(16'h1F28, 32'd100, "R10 write beats increment");

    wr(16'h1E80, 32'hFFFF01FF);
    wr(16'h1F0C, 32'hFFFFFFFF);
    wr(16'h1F08, 32'hFFFFFFFE);
    wr(16'h1E04, 32'h00000002);
    pulse(1, 1);
    rd(16'h1F08, 32'hFFFFFFFF, "R3 at max low");
    rd(16'h0808, 32'h0, "R3 no early pending");
    pulse(1, 1);
    rd(16'h1F08, 32'h0, "R3 wrapped low");
    rd(16'h1F0C, 32'h0, "R3 wrapped high");
    rd(16'h0808, 32'h00000002, "R3 pending set");
    chk_irq(1'b0, "R7 masked");
    wr(16'h0804, 32'h0000FFFD);
    chk_irq(1'b1, "R7 unmasked");
    wr(16'h080C, 32'h00000001);
    rd(16'h0808, 32'h00000002, "R8 other bit kept");
    wr(16'h080C, 32'h00000002);
    rd(16'h0808, 32'h0, "R8 cleared");
    chk_irq(1'b0, "R7 irq after clear");

    @(posedge clk); #1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule